// File: doc/BRIEF.md
# Accelerator Configuration Descriptor Responder

This block sits on the host-side memory-mapped request path of an accelerator. The host issues one request at a time and waits for an acknowledge before it sends the next. When a request is a configuration-space read, the block returns a word from a fixed descriptor. The descriptor tells the host how many processes the accelerator serves, which programming model it uses, and where its optional regions sit. All other requests are acknowledged with zero data and have no other effect.

The descriptor is kept as a packed record of typed fields, 640 bits in all. It is cut into ten 64-bit words and selected by address. The address is an index of 32-bit words, so a 32-bit read picks one half of a 64-bit descriptor word. The response goes through two register stages: a request register, then a plain delay stage. The read-data parity is computed directly on the data that is driven out. An address that fails its parity check still gets an acknowledge. Its response is all ones, and the block records the error.

Top module: `cfg_desc_responder`

## Requirements
- R1: After reset, `mm_ack` is 0, `mm_rdata` is 0, `mm_rdata_par` is 1 and `addr_par_err` is 0.
- R2: A request accepted on clock edge k gives `mm_ack` high for exactly the one cycle after edge k+1. The response data is on `mm_rdata` in that same cycle.
- R3: A configuration read (`mm_cfg`=1, `mm_rd`=1) with `mm_dw`=1 returns the 64-bit descriptor word at index `mm_addr`>>1. Word 0 is 64'h0000_0001_0000_8010. From the most significant end, that is: 0 interrupts per process, 1 process, 0 configuration records, programming model 16'h8010.
- R4: A configuration read with `mm_dw`=0 returns a 32-bit half, copied into both halves of `mm_rdata`. An even `mm_addr` gives bits 63:32 of descriptor word `mm_addr`>>1, and an odd `mm_addr` gives bits 31:0. For example, address 0 gives 64'h00000001_00000001 and address 1 gives 64'h00008010_00008010.
- R5: A 64-bit configuration read ignores bit 0 of `mm_addr`, so address 1 returns the same data as address 0.
- R6: Descriptor words 1 to 9 (32-bit addresses 2 to 19) are zero. Any address of 20 or more returns zero.
- R7: Configuration writes, and any request with `mm_cfg`=0, are acknowledged with zero data. Write data and write-data parity do not change the response.
- R8: `mm_rdata_par` is always the odd parity of the current `mm_rdata`, that is, the inverted XOR of its bits.
- R9: The address check passes when the XOR of `mm_addr` and `mm_addr_par` is 1. A request that fails the check is still acknowledged, returns all-ones data and sets `addr_par_err`. `addr_par_err` stays set until reset.
- R10: A valid that is sampled on the edge right after an accepted request is ignored and produces no second acknowledge.
- R11: In every cycle where `mm_ack` is low, `mm_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_valid | input | 1 | Request strobe |
| mm_cfg | input | 1 | Request targets configuration (descriptor) space |
| mm_rd | input | 1 | 1 = read, 0 = write |
| mm_dw | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mm_addr | input | 24 | 32-bit word index |
| mm_addr_par | input | 1 | Odd parity bit over `mm_addr` |
| mm_wdata | input | 64 | Write data (not used) |
| mm_wdata_par | input | 1 | Write data parity (not used) |
| mm_ack | output | 1 | Single-cycle acknowledge |
| mm_rdata | output | 64 | Response data |
| mm_rdata_par | output | 1 | Odd parity over `mm_rdata` |
| addr_par_err | output | 1 | Sticky address parity error |

## Verification
The hardest case to reach from the ports is a valid that lands on the edge right after an acceptance. A host that waits for the acknowledge never does this. The bench therefore holds valid high for two edges in a directed case, and in the random phase it sometimes stretches valid or issues the next request without waiting. The sticky parity error can hide later faults. For that reason the bad-parity cases run late in the directed sequence, and a reset in the middle of the run clears the error and is checked against R1 again.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;

  typedef struct packed {
    logic [15:0]  ints_per_proc;
    logic [15:0]  proc_count;
    logic [15:0]  cfg_rec_count;
    logic [15:0]  prog_model;
    logic [199:0] pad_a;
    logic [55:0]  rec_len;
    logic [63:0]  rec_off;
    logic [5:0]   pad_b;
    logic         psa_each_proc;
    logic         psa_needed;
    logic [55:0]  psa_len;
    logic [63:0]  psa_off;
    logic [7:0]   pad_c;
    logic [55:0]  errbuf_len;
    logic [63:0]  errbuf_off;
  } acc_desc_t;

  localparam int DESC_BITS   = $bits(acc_desc_t);
  localparam int DESC_DWORDS = DESC_BITS / DATA_W;

  typedef enum logic [1:0] {
    RSP_ZERO = 2'd0,
    RSP_DESC = 2'd1,
    RSP_FAIL = 2'd2
  } rsp_kind_t;

  function automatic acc_desc_t build_desc();
    acc_desc_t d;
    d               = '0;
    d.ints_per_proc = 16'd0;
    d.proc_count    = 16'd1;
    d.cfg_rec_count = 16'd0;
    d.prog_model    = 16'h8010;
    return d;
  endfunction

  // Pick the lane for a 32-bit read, or pass the whole word for a 64-bit one
  function automatic logic [DATA_W-1:0] lane_pick(logic [DATA_W-1:0] word,
                                                 logic lo_half, logic wide);
    logic [HALF_W-1:0] h;
    h = lo_half ? word[HALF_W-1:0] : word[DATA_W-1:HALF_W];
    return wide ? word : {h, h};
  endfunction

  function automatic rsp_kind_t classify(logic addr_ok, logic cfg, logic rd);
    if (!addr_ok)      return RSP_FAIL;
    else if (cfg && rd) return RSP_DESC;
    else               return RSP_ZERO;
  endfunction

endpackage

// File: rtl/cdr_delay.sv
module cdr_delay #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cdr_desc_rom.sv
module cdr_desc_rom
  import cdr_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NDW   = DESC_DWORDS,
  parameter int IDX_W = ADDR_W - 1
) (
  input  logic [IDX_W-1:0] dw_idx,
  output logic [DW-1:0]    dw_data,
  output logic             in_range
);
  localparam acc_desc_t         DESC      = build_desc();
  localparam logic [NDW*DW-1:0] DESC_FLAT = DESC;

  logic [DW-1:0] words [NDW];

  // Word 0 is the most significant slice of the record
  for (genvar g = 0; g < NDW; g++) begin : g_slice
    assign words[g] = DESC_FLAT[NDW*DW-1-g*DW -: DW];
  end

  always_comb begin
    dw_data  = '0;
    in_range = 1'b0;
    for (int i = 0; i < NDW; i++) begin
      if (dw_idx == IDX_W'(i)) begin
        dw_data  = words[i];
        in_range = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdr_req_ctrl.sv
module cdr_req_ctrl
  import cdr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          cfg,
  input  logic          rd,
  input  logic          wide,
  input  logic [AW-1:0] addr,
  input  logic          addr_par,
  input  logic [DW-1:0] wdata,
  input  logic          wdata_par,
  input  logic [DW-1:0] rom_data,
  input  logic          rom_in_range,
  output logic [AW-2:0] rom_idx,
  output logic          s1_ack,
  output logic [DW-1:0] s1_data,
  output logic          par_err
);
  logic          accept;
  logic          addr_ok;
  rsp_kind_t     kind;
  logic [DW-1:0] resp;
  logic          evt_write_ok;
  logic          evt_oor_read;
  logic          evt_bad_addr;

  assign rom_idx = addr[AW-1:1];
  assign addr_ok = ^{addr, addr_par};
  // One-edge hold-off after an acceptance
  assign accept  = valid & ~s1_ack;
  assign kind    = classify(addr_ok, cfg, rd);

  assign evt_write_ok = accept & addr_ok & ~rd;
  assign evt_oor_read = accept & addr_ok & cfg & rd & ~rom_in_range;
  assign evt_bad_addr = accept & ~addr_ok;

  always_comb begin
    case (kind)
      RSP_DESC: resp = lane_pick(rom_data, addr[0], wide);
      RSP_FAIL: resp = '1;
      default:  resp = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ack  <= 1'b0;
      s1_data <= '0;
    end else if (accept) begin
      s1_ack  <= 1'b1;
      s1_data <= resp;
    end else begin
      s1_ack  <= 1'b0;
      s1_data <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            par_err <= 1'b0;
    else if (evt_bad_addr) par_err <= 1'b1;
  end

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_write_ok && (wdata != '0 || wdata_par)) |=> s1_data == '0); // R7
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_oor_read |=> s1_data == '0); // R6
  AST_BAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bad_addr |=> (s1_data == '1 && par_err)); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err); // R9
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_ack && valid) |=> !s1_ack); // R10
endmodule

// File: rtl/cfg_desc_responder.sv
module cfg_desc_responder
  import cdr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mm_valid,
  input  logic          mm_cfg,
  input  logic          mm_rd,
  input  logic          mm_dw,
  input  logic [AW-1:0] mm_addr,
  input  logic          mm_addr_par,
  input  logic [DW-1:0] mm_wdata,
  input  logic          mm_wdata_par,
  output logic          mm_ack,
  output logic [DW-1:0] mm_rdata,
  output logic          mm_rdata_par,
  output logic          addr_par_err
);
  logic [AW-2:0] rom_idx;
  logic [DW-1:0] rom_data;
  logic          rom_in_range;
  logic          s1_ack;
  logic [DW-1:0] s1_data;

  cdr_desc_rom #(.DW(DW), .NDW(DESC_DWORDS), .IDX_W(AW-1)) u_rom (
    .dw_idx   (rom_idx),
    .dw_data  (rom_data),
    .in_range (rom_in_range)
  );

  cdr_req_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (mm_valid),
    .cfg          (mm_cfg),
    .rd           (mm_rd),
    .wide         (mm_dw),
    .addr         (mm_addr),
    .addr_par     (mm_addr_par),
    .wdata        (mm_wdata),
    .wdata_par    (mm_wdata_par),
    .rom_data     (rom_data),
    .rom_in_range (rom_in_range),
    .rom_idx      (rom_idx),
    .s1_ack       (s1_ack),
    .s1_data      (s1_data),
    .par_err      (addr_par_err)
  );

  cdr_delay #(.W(1)) u_ack_dly (
    .clk (clk), .rst_n (rst_n), .d (s1_ack), .q (mm_ack)
  );

  cdr_delay #(.W(DW)) u_data_dly (
    .clk (clk), .rst_n (rst_n), .d (s1_data), .q (mm_rdata)
  );

  // Parity taken on the bus as driven, not carried through the delay
  assign mm_rdata_par = ~^mm_rdata;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mm_ack |=> !mm_ack); // R2
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_ack |=> (mm_ack && mm_rdata == $past(s1_data))); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_ack |-> mm_rdata == '0); // R11
  AST_ONES_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rdata == '1) |-> mm_rdata_par); // R8
endmodule

// File: tb/sim_cfg_desc_responder.sv
`timescale 1ns/1ps
module sim_cfg_desc_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mm_valid = 1'b0, mm_cfg = 1'b0, mm_rd = 1'b0, mm_dw = 1'b0;
  logic [23:0] mm_addr = '0;
  logic        mm_addr_par = 1'b1;
  logic [63:0] mm_wdata = '0;
  logic        mm_wdata_par = 1'b0;
  logic        mm_ack, mm_rdata_par, addr_par_err;
  logic [63:0] mm_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  cfg_desc_responder u0 (
    .clk(clk), .rst_n(rst_n), .mm_valid(mm_valid), .mm_cfg(mm_cfg),
    .mm_rd(mm_rd), .mm_dw(mm_dw), .mm_addr(mm_addr), .mm_addr_par(mm_addr_par),
    .mm_wdata(mm_wdata), .mm_wdata_par(mm_wdata_par), .mm_ack(mm_ack),
    .mm_rdata(mm_rdata), .mm_rdata_par(mm_rdata_par), .addr_par_err(addr_par_err)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // Reference: descriptor seen as a list of 32-bit words
  function automatic logic [31:0] ref_word(int unsigned i);
    if (i == 0)      return 32'h0000_0001;
    else if (i == 1) return 32'h0000_8010;
    else             return 32'h0;
  endfunction

  function automatic logic [63:0] ref_resp(logic cfg, logic rd, logic dw,
                                           logic [23:0] a, logic p);
    int unsigned base;
    if ((^a) == p) return '1;
    if (!(cfg && rd)) return '0;
    if (dw) begin
      base = int'(a) & ~1;
      return {ref_word(base), ref_word(base + 1)};
    end
    return {ref_word(int'(a)), ref_word(int'(a))};
  endfunction

  // Behavioural model: latency counted in edges
  logic        m_s1_ack, m_ack, m_err;
  logic [63:0] m_s1_data, m_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1_ack = 0; m_ack = 0; m_err = 0; m_s1_data = '0; m_data = '0;
    end else begin
      m_ack  = m_s1_ack;
      m_data = m_s1_data;
      if (mm_valid && !m_s1_ack) begin
        m_s1_ack  = 1;
        m_s1_data = ref_resp(mm_cfg, mm_rd, mm_dw, mm_addr, mm_addr_par);
        if ((^mm_addr) == mm_addr_par) m_err = 1;
      end else begin
        m_s1_ack  = 0;
        m_s1_data = '0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 ack", {63'b0, mm_ack}, {63'b0, m_ack});
      chk(m_ack ? "R3 data" : "R11 idle", mm_rdata, m_data);
      chk("R8 parity", {63'b0, mm_rdata_par}, {63'b0, ~^m_data});
      chk("R9 sticky", {63'b0, addr_par_err}, {63'b0, m_err});
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog R2: got hung run expected completion");
      summary();
      $finish;
    end
  end

  task automatic drive(logic cfg, logic rd, logic dw, logic [23:0] a, bit bad);
    mm_valid = 1; mm_cfg = cfg; mm_rd = rd; mm_dw = dw; mm_addr = a;
    mm_addr_par = bad ? (^a) : ~(^a);
    mm_wdata = {$urandom, $urandom}; mm_wdata_par = 1'($urandom);
  endtask

  // Request on one edge, check the ack cycle and the cycle after
  task automatic req(string tag, logic cfg, logic rd, logic dw,
                     logic [23:0] a, bit bad, logic [63:0] exp);
    @(negedge clk); drive(cfg, rd, dw, a, bad);
    @(negedge clk); mm_valid = 0;
    @(negedge clk);
    chk({tag, " ack"}, {63'b0, mm_ack}, 64'd1);
    chk({tag, " data"}, mm_rdata, exp);
    @(negedge clk);
    chk({tag, " ack drop"}, {63'b0, mm_ack}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ack", {63'b0, mm_ack}, 0);
    chk("R1 data", mm_rdata, 0);
    chk("R1 par", {63'b0, mm_rdata_par}, 1);
    chk("R1 err", {63'b0, addr_par_err}, 0);

    req("R3 dword0", 1, 1, 1, 24'd0, 0, 64'h0000_0001_0000_8010);
    req("R4 even", 1, 1, 0, 24'd0, 0, 64'h0000_0001_0000_0001);
    req("R4 odd", 1, 1, 0, 24'd1, 0, 64'h0000_8010_0000_8010);
    req("R4 zero half", 1, 1, 0, 24'd2, 0, 64'h0);
    req("R5 odd wide", 1, 1, 1, 24'd1, 0, 64'h0000_0001_0000_8010);
    req("R6 last dword", 1, 1, 1, 24'd18, 0, 64'h0);
    req("R6 last half", 1, 1, 0, 24'd19, 0, 64'h0);
    req("R6 past end", 1, 1, 1, 24'd20, 0, 64'h0);
    req("R6 far", 1, 1, 0, 24'hFFFFFE, 0, 64'h0);
    req("R7 cfg write", 1, 0, 1, 24'd0, 0, 64'h0);
    req("R7 app read", 0, 1, 1, 24'd0, 0, 64'h0);
    req("R7 app write", 0, 0, 0, 24'd1, 0, 64'h0);

    // R10: valid held across two edges yields one ack
    @(negedge clk); drive(1, 1, 1, 24'd0, 0);
    @(negedge clk);
    @(negedge clk); mm_valid = 0;
    chk("R10 first ack", {63'b0, mm_ack}, 1);
    @(negedge clk);
    chk("R10 no second ack", {63'b0, mm_ack}, 0);
    @(negedge clk);
    chk("R10 still quiet", {63'b0, mm_ack}, 0);

    // R9: bad parity, then a good read with the flag still set
    req("R9 bad addr", 1, 1, 1, 24'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 flag set", {63'b0, addr_par_err}, 1);
    req("R9 good after", 1, 1, 0, 24'd1, 0, 64'h0000_8010_0000_8010);
    chk("R9 flag held", {63'b0, addr_par_err}, 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 err cleared", {63'b0, addr_par_err}, 0);
    chk("R1 data after reset", mm_rdata, 0);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned gap;
      int unsigned hold;
      logic [23:0] a;
      a = ($urandom_range(0, 9) == 0) ? 24'($urandom) : 24'($urandom_range(0, 23));
      @(negedge clk);
      drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
            1'($urandom), a, $urandom_range(0, 19) == 0);
      hold = $urandom_range(1, 3);
      repeat (hold) @(negedge clk);
      mm_valid = 0;
      gap = $urandom_range(0, 3);
      repeat (gap) @(negedge clk);
    end
    repeat (4) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule